// File: doc/BRIEF.md
# Four-by-Four to Three-by-Three Pixel Tile Reducer

This block shrinks a square tile of sixteen 24-bit colour pixels into a tile of nine pixels of the same format. Feeding it the 25x25 grid of 4x4 tiles that covers a 100x100 frame gives a 75x75 frame. Each output tile keeps the grid position of its input tile. Reading the raster and buffering lines or frames is done elsewhere.

Every output pixel is computed by arithmetic on the red, green and blue bytes separately. No lookup table is used. A one-bit mode input picks the reduction rule for each tile. The corner-keeping rule copies the four corners, averages the two inner pixels along each edge, and averages the four central pixels for the middle. The sliding-mean rule sets every output pixel to the rounded mean of an overlapping 2x2 window.

Both the input tile and the output tile use a valid/ready handshake. A single register stage sits between them. A tile that is accepted appears at the output one clock later. With the output always ready, the block takes one tile per clock.

Top module: `tile_reducer`

## Requirements
- R1: While `rst` (active-high, synchronous) is high at a clock edge, the block clears `out_valid` to 0 and `out_tile` to all zeros on that edge.
- R2: With `in_mode` = 0 (corner-keeping), each output corner equals the matching input corner: S00=B00, S02=B03, S20=B30, S22=B33.
- R3: With `in_mode` = 0, each output edge pixel is the rounded mean of the two inner input pixels on the same edge: S01 from B01,B02; S21 from B31,B32; S10 from B10,B20; S12 from B13,B23.
- R4: With `in_mode` = 0, the centre S11 is the rounded mean of B11, B12, B21 and B22.
- R5: With `in_mode` = 1 (sliding mean), every output Sij is the rounded mean of B(i)(j), B(i)(j+1), B(i+1)(j) and B(i+1)(j+1).
- R6: All averaging is done per 8-bit channel, and no carry passes from one channel into another. Rounding is half-up: a two-pixel mean is (a+b+1)>>1 and a four-pixel mean is (a+b+c+d+2)>>2. A channel value of 255 in every input gives 255 with no wrap.
- R7: A tile accepted on an edge (`in_valid` and `in_ready` both high) shows up on `out_valid`/`out_tile` right after that edge. While `out_ready` stays high, `in_ready` stays high, so one tile per clock is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_tile` hold their values. Nothing on `in_tile` or `in_mode` affects the output unless the tile is accepted.
- R9: The mode is captured together with each accepted tile. Tiles accepted back to back with different modes are each reduced by their own mode.
- R10: Tiles are packed row-major. Input pixel Brc sits at bits [(4r+c)*24 +: 24] and output pixel Sij at bits [(3i+j)*24 +: 24]. Within a pixel, red is in bits 23:16, green in 15:8 and blue in 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input tile is offered |
| in_ready | output | 1 | The block can take an input tile |
| in_mode | input | 1 | Rule for the offered tile: 0 corner-keeping, 1 sliding mean |
| in_tile | input | 384 | Sixteen packed input pixels |
| out_valid | output | 1 | An output tile is held |
| out_ready | input | 1 | The consumer takes the output tile |
| out_tile | output | 216 | Nine packed output pixels |

## Verification
The bench tries the block with several kinds of tile:
- A per-pixel ramp in both modes. Every source pixel is different, so a wrong tap or a swapped edge shows up.
- Tiles with a single lit pixel in B00 or B33. These pin down the packing order and the byte order.
- All-255 tiles, which expose adder overflow.
- A tile with 255 and 0 in alternating channels, which exposes carry leaking between channels.
- Odd channel sums, which separate half-up rounding from truncation.
- Random tiles that alternate mode every cycle, which show whether the mode is captured per tile.
- Random tiles under random and alternating back-pressure, which test holding and ordering.
- A reset while a tile is pending.

// File: rtl/tile_red_pkg.sv
package tile_red_pkg;

    localparam int CH_W    = 8;
    localparam int N_CH    = 3;
    localparam int PIX_W   = CH_W * N_CH;
    localparam int IN_DIM  = 4;
    localparam int OUT_DIM = 3;
    localparam int IN_PIX  = IN_DIM * IN_DIM;
    localparam int OUT_PIX = OUT_DIM * OUT_DIM;
    localparam int IN_W    = IN_PIX * PIX_W;
    localparam int OUT_W   = OUT_PIX * PIX_W;
    localparam int TAPS    = 4;
    localparam int SHIFT   = $clog2(TAPS);
    localparam int SUM_W   = CH_W + SHIFT;
    localparam int BIAS    = TAPS / 2;
    localparam int IDX_W   = $clog2(IN_PIX);

    typedef enum logic {
        RED_CORNER = 1'b0,
        RED_MEAN   = 1'b1
    } red_mode_e;

    typedef logic [PIX_W-1:0]            pixel_t;
    typedef logic [TAPS-1:0][IDX_W-1:0]  quad_sel_t;
    typedef logic [TAPS-1:0][PIX_W-1:0]  quad_pix_t;

    // Source row (or column) pair feeding output line o.
    // Corner-keeping: outer lines repeat the edge line, the middle line
    // spans the two inner lines. Sliding mean: lines o and o+1.
    function automatic int line_lo(red_mode_e m, int o);
        if (m == RED_MEAN) return o;
        return (o == 0) ? 0 : ((o == OUT_DIM - 1) ? IN_DIM - 1 : 1);
    endfunction

    function automatic int line_hi(red_mode_e m, int o);
        if (m == RED_MEAN) return o + 1;
        return (o == 0) ? 0 : ((o == OUT_DIM - 1) ? IN_DIM - 1 : 2);
    endfunction

    // Four source pixel indices for output (oi, oj). A copied corner
    // repeats one pixel four times; an edge pair appears twice each,
    // so one rounded four-tap mean serves all three cases.
    function automatic quad_sel_t pick_sources(red_mode_e m, int oi, int oj);
        quad_sel_t q;
        q[0] = IDX_W'(line_lo(m, oi) * IN_DIM + line_lo(m, oj));
        q[1] = IDX_W'(line_lo(m, oi) * IN_DIM + line_hi(m, oj));
        q[2] = IDX_W'(line_hi(m, oi) * IN_DIM + line_lo(m, oj));
        q[3] = IDX_W'(line_hi(m, oi) * IN_DIM + line_hi(m, oj));
        return q;
    endfunction

endpackage

// File: rtl/tile_avg4.sv
module tile_avg4
    import tile_red_pkg::*;
(
    input  quad_pix_t win_i,
    output pixel_t    pix_o
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [SUM_W-1:0] acc;

        always_comb begin
            acc = SUM_W'(BIAS);
            for (int k = 0; k < TAPS; k++) begin
                acc = acc + SUM_W'(win_i[k][c*CH_W +: CH_W]);
            end
        end

        assign pix_o[c*CH_W +: CH_W] = acc[SHIFT +: CH_W];
    end

endmodule

// File: rtl/tile_reduce_kernel.sv
module tile_reduce_kernel
    import tile_red_pkg::*;
(
    input  red_mode_e          mode_i,
    input  logic [IN_W-1:0]    tile_i,
    output logic [OUT_W-1:0]   tile_o
);

    for (genvar i = 0; i < OUT_DIM; i++) begin : g_row
        for (genvar j = 0; j < OUT_DIM; j++) begin : g_col
            localparam quad_sel_t SEL_C = pick_sources(RED_CORNER, i, j);
            localparam quad_sel_t SEL_M = pick_sources(RED_MEAN, i, j);

            quad_pix_t win;

            for (genvar k = 0; k < TAPS; k++) begin : g_tap
                assign win[k] = (mode_i == RED_CORNER)
                              ? tile_i[int'(SEL_C[k])*PIX_W +: PIX_W]
                              : tile_i[int'(SEL_M[k])*PIX_W +: PIX_W];
            end

            tile_avg4 u_avg (
                .win_i (win),
                .pix_o (tile_o[(i*OUT_DIM + j)*PIX_W +: PIX_W])
            );
        end
    end

endmodule

// File: rtl/tile_reducer.sv
module tile_reducer
    import tile_red_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_mode,
    input  logic [IN_W-1:0]  in_tile,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_tile
);

    logic [OUT_W-1:0] next_tile;
    logic             accept;

    tile_reduce_kernel u_kernel (
        .mode_i (red_mode_e'(in_mode)),
        .tile_i (in_tile),
        .tile_o (next_tile)
    );

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tile  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_tile <= next_tile;
            end
        end
    end

    // R1: reset empties the output register
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_tile == '0));

    // R7: an accepted tile is presented on the next cycle
    p_accept_latency_r7: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    // R8: a stalled output holds still and blocks the input
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tile)));

    p_stall_block_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R2, R9: corner-keeping tile copies B00 into S00
    p_corner_copy_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && in_mode == 1'b0) |=> (out_tile[PIX_W-1:0] == $past(in_tile[PIX_W-1:0])));

endmodule

// File: tb/tile_reducer_tb.sv
`timescale 1ns/1ps
module tile_reducer_tb;
    import tile_red_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_mode = 1'b0;
    logic [IN_W-1:0] in_tile = '0;
    logic out_ready = 1'b0;
    logic in_ready, out_valid;
    logic [OUT_W-1:0] out_tile;

    tile_reducer u_dut (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_mode (in_mode), .in_tile (in_tile),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_tile (out_tile)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [OUT_W-1:0] exp;
        string            tag;
        int               acc_cyc;
        bit               full;
    } item_t;

    item_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int rdy_pat = 3;   // 0 always, 1 alternate, 2 random, 3 never
    int stalls = 0;
    bit done = 1'b0;
    bit hold_prev = 1'b0;
    logic [OUT_W-1:0] prev_tile;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] px(logic [IN_W-1:0] t, int r, int c);
        return t[(r*4 + c)*24 +: 24];
    endfunction

    function automatic logic [23:0] avg2(logic [23:0] a, logic [23:0] b);
        logic [23:0] o;
        for (int ch = 0; ch < 3; ch++)
            o[ch*8 +: 8] = 8'((int'(a[ch*8 +: 8]) + int'(b[ch*8 +: 8]) + 1) >> 1);
        return o;
    endfunction

    function automatic logic [23:0] avg4(logic [23:0] a, logic [23:0] b,
                                         logic [23:0] c, logic [23:0] d);
        logic [23:0] o;
        for (int ch = 0; ch < 3; ch++)
            o[ch*8 +: 8] = 8'((int'(a[ch*8 +: 8]) + int'(b[ch*8 +: 8]) +
                              int'(c[ch*8 +: 8]) + int'(d[ch*8 +: 8]) + 2) >> 2);
        return o;
    endfunction

    function automatic logic [OUT_W-1:0] model(logic [IN_W-1:0] t, logic m);
        logic [OUT_W-1:0] o;
        o = '0;
        if (m) begin
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++)
                    o[(i*3 + j)*24 +: 24] = avg4(px(t,i,j), px(t,i,j+1),
                                                 px(t,i+1,j), px(t,i+1,j+1));
        end else begin
            o[0*24 +: 24] = px(t,0,0);
            o[1*24 +: 24] = avg2(px(t,0,1), px(t,0,2));
            o[2*24 +: 24] = px(t,0,3);
            o[3*24 +: 24] = avg2(px(t,1,0), px(t,2,0));
            o[4*24 +: 24] = avg4(px(t,1,1), px(t,1,2), px(t,2,1), px(t,2,2));
            o[5*24 +: 24] = avg2(px(t,1,3), px(t,2,3));
            o[6*24 +: 24] = px(t,3,0);
            o[7*24 +: 24] = avg2(px(t,3,1), px(t,3,2));
            o[8*24 +: 24] = px(t,3,3);
        end
        return o;
    endfunction

    function automatic logic [IN_W-1:0] rand_tile();
        logic [IN_W-1:0] t;
        for (int k = 0; k < IN_W/32; k++) t[k*32 +: 32] = $urandom;
        return t;
    endfunction

    task automatic send_exp(logic [IN_W-1:0] t, logic m, logic [OUT_W-1:0] exp, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_tile  = t;
        in_mode  = m;
        #1;
        if (rdy_pat == 0 && !in_ready) stalls++;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        sb.push_back('{exp, tag, cyc, (rdy_pat == 0)});
    endtask

    task automatic send(logic [IN_W-1:0] t, logic m, string tag);
        send_exp(t, m, model(t, m), tag);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_tile  = rand_tile();   // junk while not valid (R8)
            in_mode  = $urandom % 2;
        end
    endtask

    task automatic drain();
        idle(1);
        while (sb.size() != 0) idle(1);
        idle(2);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: drives back-pressure and pops the scoreboard
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            case (rdy_pat)
                0: out_ready = 1'b1;
                1: out_ready = cyc[0];
                2: out_ready = ($urandom % 3) != 0;
                default: out_ready = 1'b0;
            endcase
            #1;
            if (!rst) begin
                if (hold_prev) begin
                    chk_int("R8 valid held in stall", int'(out_valid), 1);
                    chk("R8 tile held in stall", out_tile, prev_tile);
                end
                hold_prev = out_valid && !out_ready;
                prev_tile = out_tile;
                if (out_valid && out_ready) begin
                    if (sb.size() == 0) begin
                        n_cmp++;
                        n_bad++;
                        $display("FAIL R7: actual=unexpected tile expected=none");
                    end else begin
                        it = sb.pop_front();
                        chk(it.tag, out_tile, it.exp);
                        if (it.full) chk_int("R7 latency", cyc - it.acc_cyc, 1);
                    end
                end
            end else begin
                hold_prev = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    // Driver
    initial begin
        logic [IN_W-1:0] t;
        logic [OUT_W-1:0] e;

        repeat (3) @(negedge clk);
        #1;
        chk_int("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset tile", out_tile, '0);
        @(negedge clk);
        rst = 1'b0;
        rdy_pat = 0;

        // Ramp tile, both modes (R2 R3 R4 R5)
        for (int k = 0; k < 16; k++)
            t[k*24 +: 24] = {8'(16*k), 8'(3*k + 1), 8'(255 - 7*k)};
        send(t, 1'b0, "R2 R3 R4 corner ramp");
        send(t, 1'b1, "R5 mean ramp");

        // Packing R10: only B33 lit
        t = '0;
        t[15*24 +: 24] = 24'h123456;
        e = '0;
        e[8*24 +: 24] = 24'h123456;
        send_exp(t, 1'b0, e, "R10 R2 corner B33 to S22");
        e = '0;
        e[8*24 +: 24] = 24'h050d16;
        send_exp(t, 1'b1, e, "R10 R5 mean B33 into S22");
        t = '0;
        t[23:0] = 24'hff0102;
        e = '0;
        e[23:0] = 24'hff0102;
        send_exp(t, 1'b0, e, "R10 R2 corner B00 to S00");

        // Overflow: all 255 (R6)
        t = '1;
        send_exp(t, 1'b0, '1, "R6 all-255 corner");
        send_exp(t, 1'b1, '1, "R6 all-255 mean");

        // Channel isolation (R6)
        for (int k = 0; k < 16; k++) t[k*24 +: 24] = 24'hff00ff;
        send_exp(t, 1'b1, {9{24'hff00ff}}, "R6 channel isolation");

        // Rounding: odd sums (R6 R3)
        for (int k = 0; k < 16; k++) t[k*24 +: 24] = {8'(k % 2), 8'(k % 3), 8'((k*5) % 4)};
        send(t, 1'b0, "R6 R3 rounding corner");
        send(t, 1'b1, "R6 R5 rounding mean");
        t = '0;
        t[1*24 +: 24] = 24'h000001;
        t[2*24 +: 24] = 24'h000002;
        e = '0;
        e[1*24 +: 24] = 24'h000002;
        send_exp(t, 1'b0, e, "R6 R3 half-up (1+2)/2");

        // Back-to-back with alternating mode (R9 R7)
        stalls = 0;
        for (int k = 0; k < 24; k++) send(rand_tile(), k[0], "R9 alternating mode");
        chk_int("R7 no input stall at full rate", stalls, 0);
        drain();

        // Back-pressure patterns (R8)
        rdy_pat = 1;
        for (int k = 0; k < 30; k++) send(rand_tile(), $urandom % 2, "R8 alternate ready");
        drain();
        rdy_pat = 2;
        for (int k = 0; k < 60; k++) begin
            send(rand_tile(), $urandom % 2, "R8 random ready");
            if ($urandom % 4 == 0) idle(1);
        end
        drain();

        // Reset with a tile pending (R1)
        rdy_pat = 3;
        send(rand_tile(), 1'b1, "R1 pending");
        idle(1);
        #1;
        chk_int("R1 pending tile held", int'(out_valid), 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk_int("R1 mid-run reset valid", int'(out_valid), 0);
        chk("R1 mid-run reset tile", out_tile, '0);
        sb.delete();
        @(negedge clk);
        rst = 1'b0;
        rdy_pat = 0;
        send(rand_tile(), 1'b0, "R2 after reset");
        drain();

        summary();
    end

endmodule